// File: doc/BRIEF.md
# Iterative Integer ALU

This block is the integer arithmetic unit of a processor datapath. Logical, shift, add and subtract operations finish in one clock. Multiplication and division are done literally, as loops. A product is built by adding the multiplicand to an accumulator once per clock while a counter loaded with the multiplier runs down to zero. A quotient is built by taking the divisor away from a running remainder while the remainder is still at least the divisor, counting one per subtraction. Their latency therefore depends on the operand values.

The datapath pulses `start_i` together with an operation code and two unsigned operands. Operands are sampled on the accepting edge only, so they may change freely afterwards. While a loop runs, `busy_o` is high and further starts are dropped. Every accepted operation ends with exactly one `done_o` pulse. Results stay on the outputs until the next operation is accepted.

Top module: `iter_alu`

## Requirements
- R1: The operation code selects the function, with codes 0 AND, 1 OR, 2 XOR, 3 NOR, 4 NAND and 5 NOT of A. For these codes the carry is 0.
- R2: Code 6 shifts A left by one position and fills bit 0 with 0. The carry takes the old top bit of A.
- R3: Code 7 shifts A right by one position and fills the top bit with 0. The carry takes the old bit 0 of A.
- R4: Code 8 gives A+B modulo 2^W, and the carry is the carry out. Code 9 gives A-B modulo 2^W, and the carry is 1 exactly when A<B (borrow).
- R5: Codes 0 to 9 and the unused codes 12 to 15 raise `done_o` in the clock cycle right after the accepting edge. `busy_o` stays low for them. Unused codes give result 0 and carry 0.
- R6: Code 10 gives the low W bits of A*B. The carry is 1 when the full product does not fit in W bits. `done_o` appears B cycles after the accepting edge. B=0 finishes like a single-cycle operation, with result 0.
- R7: Code 11 with B not 0 gives the quotient floor(A/B) on `result_o` and A mod B on `remainder_o`, with carry 0. `done_o` appears floor(A/B)+1 cycles after the accepting edge.
- R8: Code 11 with B=0 finishes like a single-cycle operation. The result is all ones, the remainder is A and `div_err_o` is 1.
- R9: `busy_o` is high from the cycle after a loop operation is accepted until its `done_o`. `done_o` and `busy_o` are never high together.
- R10: A start that arrives while `busy_o` is high is ignored. It does not produce a `done_o` pulse and it does not change the running operation's result.
- R11: Operands are taken only on the accepting edge. Result, remainder, carry and error hold their values from `done_o` until the next accepted start.
- R12: `remainder_o` and `div_err_o` read 0 after any operation other than divide. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when not busy |
| op_i | input | 4 | Operation code |
| a_i | input | W | Operand A (dividend, multiplicand, shift source) |
| b_i | input | W | Operand B (divisor, multiplier) |
| result_o | output | W | Result or quotient |
| remainder_o | output | W | Remainder of divide |
| carry_o | output | 1 | Carry, borrow, shifted-out bit or product overflow |
| div_err_o | output | 1 | Division by zero |
| busy_o | output | 1 | Loop operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on a few input rules. `start_i`, `op_i` and the operands must be known on every edge after reset. An operation's expected outcome is tied only to the operand values present on the accepting edge. The stimulus drives inputs only at the falling edge and launches a new operation only once the previous one has reported. It deliberately puts unrelated values on the operands, and one stray start, while a loop is running, to show that nothing is sampled outside the accepting edge.

// File: rtl/iter_alu_pkg.sv
package iter_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND  = 4'h0,
        OP_OR   = 4'h1,
        OP_XOR  = 4'h2,
        OP_NOR  = 4'h3,
        OP_NAND = 4'h4,
        OP_NOT  = 4'h5,
        OP_SHL  = 4'h6,
        OP_SHR  = 4'h7,
        OP_ADD  = 4'h8,
        OP_SUB  = 4'h9,
        OP_MUL  = 4'hA,
        OP_DIV  = 4'hB
    } alu_op_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_MUL  = 2'd1,
        ENG_DIV  = 2'd2
    } eng_state_e;

endpackage

// File: rtl/alu_single_op.sv
module alu_single_op
    import iter_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);

    logic [W:0] wide;

    always_comb begin
        res_o = '0;
        cy_o  = 1'b0;
        wide  = '0;
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOR:  res_o = ~(a_i | b_i);
            OP_NAND: res_o = ~(a_i & b_i);
            OP_NOT:  res_o = ~a_i;
            OP_SHL: begin
                res_o = {a_i[W-2:0], 1'b0};
                cy_o  = a_i[W-1];
            end
            OP_SHR: begin
                res_o = {1'b0, a_i[W-1:1]};
                cy_o  = a_i[0];
            end
            OP_ADD: begin
                wide  = {1'b0, a_i} + {1'b0, b_i};
                res_o = wide[W-1:0];
                cy_o  = wide[W];
            end
            OP_SUB: begin
                wide  = {1'b0, a_i} - {1'b0, b_i};
                res_o = wide[W-1:0];
                cy_o  = wide[W];
            end
            default: begin
                res_o = '0;
                cy_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_iter_engine.sv
module alu_iter_engine
    import iter_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch_i,
    input  logic         is_div_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         fin_o,
    output logic [W-1:0] res_o,
    output logic [W-1:0] rem_o,
    output logic         cy_o,
    output logic         err_o
);

    typedef struct packed {
        eng_state_e   st;
        logic [W-1:0] acc;
        logic [W-1:0] cnt;
        logic [W-1:0] opa;
        logic [W-1:0] opb;
        logic [W-1:0] rem;
        logic         cy;
        logic         fin;
        logic         err;
    } eng_t;

    eng_t       eng_q, eng_d;
    logic [W:0] sum;

    always_comb begin
        eng_d     = eng_q;
        eng_d.fin = 1'b0;
        sum       = {1'b0, eng_q.acc} + {1'b0, eng_q.opa};
        case (eng_q.st)
            ENG_IDLE: begin
                if (launch_i) begin
                    eng_d.cy  = 1'b0;
                    eng_d.err = 1'b0;
                    eng_d.rem = '0;
                    eng_d.acc = '0;
                    if (!is_div_i) begin
                        if (b_i == '0) begin
                            eng_d.fin = 1'b1;
                        end else begin
                            eng_d.st  = ENG_MUL;
                            eng_d.cnt = b_i;
                            eng_d.opa = a_i;
                        end
                    end else begin
                        if (b_i == '0) begin
                            eng_d.fin = 1'b1;
                            eng_d.acc = '1;
                            eng_d.rem = a_i;
                            eng_d.err = 1'b1;
                        end else begin
                            eng_d.st  = ENG_DIV;
                            eng_d.rem = a_i;
                            eng_d.opb = b_i;
                        end
                    end
                end
            end
            ENG_MUL: begin
                eng_d.acc = sum[W-1:0];
                eng_d.cy  = eng_q.cy | sum[W];
                eng_d.cnt = eng_q.cnt - 1'b1;
                if (eng_q.cnt == W'(1)) begin
                    eng_d.st  = ENG_IDLE;
                    eng_d.fin = 1'b1;
                end
            end
            ENG_DIV: begin
                if (eng_q.rem >= eng_q.opb) begin
                    eng_d.rem = eng_q.rem - eng_q.opb;
                    eng_d.acc = eng_q.acc + 1'b1;
                end else begin
                    eng_d.st  = ENG_IDLE;
                    eng_d.fin = 1'b1;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ENG_IDLE, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy_o = (eng_q.st != ENG_IDLE);
    assign fin_o  = eng_q.fin;
    assign res_o  = eng_q.acc;
    assign rem_o  = eng_q.rem;
    assign cy_o   = eng_q.cy;
    assign err_o  = eng_q.err;

    AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> (eng_q.st == ENG_IDLE)); // R10

    AST_MUL_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_MUL) |-> (eng_q.cnt != '0)); // R6

    AST_MUL_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_MUL) |=> (eng_q.cnt == $past(eng_q.cnt) - 1'b1)); // R6

    AST_DIV_STOPS_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_DIV && eng_q.rem < eng_q.opb) |=> (fin_o && !busy_o)); // R7

endmodule

// File: rtl/iter_alu.sv
module iter_alu
    import iter_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] result_o,
    output logic [W-1:0] remainder_o,
    output logic         carry_o,
    output logic         div_err_o,
    output logic         busy_o,
    output logic         done_o
);

    typedef struct packed {
        logic [W-1:0] res;
        logic         cy;
        logic         done;
        logic         src_eng;
    } top_t;

    top_t         top_q, top_d;
    logic [W-1:0] s_res, e_res, e_rem;
    logic         s_cy, e_cy, e_err, e_busy, e_fin;
    logic         accept, is_iter, launch;

    assign accept  = start_i && !e_busy;
    assign is_iter = (op_i == OP_MUL) || (op_i == OP_DIV);
    assign launch  = accept && is_iter;

    alu_single_op #(.W(W)) u_single (
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (s_res),
        .cy_o  (s_cy)
    );

    alu_iter_engine #(.W(W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .is_div_i (op_i == OP_DIV),
        .a_i      (a_i),
        .b_i      (b_i),
        .busy_o   (e_busy),
        .fin_o    (e_fin),
        .res_o    (e_res),
        .rem_o    (e_rem),
        .cy_o     (e_cy),
        .err_o    (e_err)
    );

    always_comb begin
        top_d      = top_q;
        top_d.done = 1'b0;
        if (accept) begin
            if (is_iter) begin
                top_d.src_eng = 1'b1;
            end else begin
                top_d.src_eng = 1'b0;
                top_d.res     = s_res;
                top_d.cy      = s_cy;
                top_d.done    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign result_o    = top_q.src_eng ? e_res : top_q.res;
    assign remainder_o = top_q.src_eng ? e_rem : '0;
    assign carry_o     = top_q.src_eng ? e_cy  : top_q.cy;
    assign div_err_o   = top_q.src_eng ? e_err : 1'b0;
    assign busy_o      = e_busy;
    assign done_o      = top_q.done | e_fin;

    AST_DONE_EXCLUDES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R9

    AST_MUL_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i == OP_MUL && b_i != '0) |=> (busy_o && !done_o)); // R9

    AST_SHL_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i == OP_SHL) |=>
            (done_o && carry_o == $past(a_i[W-1]) && !result_o[0])); // R2

    AST_DIV_ZERO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && op_i == OP_DIV && b_i == '0) |=>
            (done_o && div_err_o && result_o == '1 && remainder_o == $past(a_i))); // R8

endmodule

// File: tb/tb_iter_alu.sv
module tb_iter_alu;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [3:0]   op = 4'h0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] result, remainder;
    logic         carry, div_err, busy, done;

    always #5 clk = ~clk;

    iter_alu #(.W(W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .op_i        (op),
        .a_i         (a),
        .b_i         (b),
        .result_o    (result),
        .remainder_o (remainder),
        .carry_o     (carry),
        .div_err_o   (div_err),
        .busy_o      (busy),
        .done_o      (done)
    );

    typedef struct {
        logic [W-1:0] res;
        logic [W-1:0] rem;
        logic         cy;
        logic         err;
        int           lat;
        int           acc_cyc;
        string        tag;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R10", "unexpected done pulse", 1, 0);
            end else begin
                mon_e = sbq.pop_front();
                chk(result == mon_e.res, mon_e.tag, "result", result, mon_e.res);
                chk(remainder == mon_e.rem && div_err == mon_e.err, mon_e.tag,
                    "remainder/err", {remainder, div_err}, {mon_e.rem, mon_e.err});
                chk(carry == mon_e.cy, mon_e.tag, "carry", carry, mon_e.cy);
                chk(cyc - mon_e.acc_cyc == mon_e.lat, mon_e.tag, "latency",
                    cyc - mon_e.acc_cyc, mon_e.lat);
            end
        end
    end

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5: return "R1";
            4'h6: return "R2";
            4'h7: return "R3";
            4'h8, 4'h9: return "R4";
            4'hA: return "R6";
            4'hB: return "R7";
            default: return "R5";
        endcase
    endfunction

    // Driver: waits for idle, computes the expectation, pushes it, strobes start
    task automatic run_op(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        exp_t           e;
        logic [2*W-1:0] p;
        logic [W:0]     w;
        while (busy || sbq.size() != 0) @(negedge clk);
        e.res = '0; e.rem = '0; e.cy = 1'b0; e.err = 1'b0; e.lat = 0;
        e.tag = tag_of(o);
        case (o)
            4'h0: e.res = x & y;
            4'h1: e.res = x | y;
            4'h2: e.res = x ^ y;
            4'h3: e.res = ~(x | y);
            4'h4: e.res = ~(x & y);
            4'h5: e.res = ~x;
            4'h6: begin e.res = x << 1; e.cy = x[W-1]; end
            4'h7: begin e.res = x >> 1; e.cy = x[0]; end
            4'h8: begin w = x + y; e.res = w[W-1:0]; e.cy = w[W]; end
            4'h9: begin e.res = x - y; e.cy = (x < y); end
            4'hA: begin
                p = x * y;
                e.res = p[W-1:0];
                e.cy = (p[2*W-1:W] != '0);
                e.lat = int'(y);
            end
            4'hB: begin
                if (y == '0) begin
                    e.res = '1; e.rem = x; e.err = 1'b1; e.tag = "R8";
                end else begin
                    e.res = x / y; e.rem = x % y; e.lat = int'(x / y) + 1;
                end
            end
            default: ;
        endcase
        e.acc_cyc = cyc + 1;
        sbq.push_back(e);
        start = 1'b1; op = o; a = x; b = y;
        @(negedge clk);
        start = 1'b0; op = 4'h8; a = ~x; b = y + 8'd3;   // R11: operands change after acceptance
    endtask

    task automatic drain();
        while (busy || sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(result == '0 && remainder == '0, "R12", "reset result/rem", result, 0);
        chk({carry, div_err, busy, done} == 4'b0, "R12", "reset flags",
            {carry, div_err, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 logic
        for (int i = 0; i < 6; i++) begin
            run_op(4'(i), 8'hC5, 8'h3A);
            run_op(4'(i), 8'hFF, 8'h0F);
        end
        // R2 / R3 shifts
        run_op(4'h6, 8'h81, 8'h00);
        run_op(4'h6, 8'h41, 8'h00);
        run_op(4'h7, 8'h81, 8'h00);
        run_op(4'h7, 8'h80, 8'h00);
        // R4 add / sub
        run_op(4'h8, 8'hF0, 8'h20);
        run_op(4'h8, 8'h10, 8'h20);
        run_op(4'h9, 8'h05, 8'h09);
        run_op(4'h9, 8'h09, 8'h05);
        // R5 unused codes
        run_op(4'hC, 8'h55, 8'hAA);
        run_op(4'hF, 8'hFF, 8'hFF);
        // R6 multiply
        run_op(4'hA, 8'd77, 8'd0);
        run_op(4'hA, 8'd77, 8'd1);
        run_op(4'hA, 8'd13, 8'd7);
        run_op(4'hA, 8'd200, 8'd3);
        run_op(4'hA, 8'd255, 8'd255);
        // R7 divide
        run_op(4'hB, 8'd100, 8'd7);
        run_op(4'hB, 8'd5, 8'd9);
        run_op(4'hB, 8'd255, 8'd1);
        run_op(4'hB, 8'd0, 8'd5);
        run_op(4'hB, 8'd42, 8'd42);
        // R8 divide by zero
        run_op(4'hB, 8'd123, 8'd0);
        // R12: divide then logic clears remainder/err
        run_op(4'hB, 8'd50, 8'd0);
        run_op(4'h0, 8'hF0, 8'h3C);
        drain();

        // R10: stray start while busy
        run_op(4'hA, 8'd9, 8'd20);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R9", "busy during multiply", busy, 1);
        start = 1'b1; op = 4'h8; a = 8'd1; b = 8'd1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R10", "stray start ignored", {busy, done}, 2);
        drain();
        // R11: values held after done
        chk(result == 8'd180 && done == 1'b0, "R11", "result held", result, 180);

        // Mixed random operations
        for (int i = 0; i < 40; i++) begin
            logic [3:0]   ro;
            logic [W-1:0] rx, ry;
            ro = 4'($urandom_range(0, 15));
            rx = W'($urandom);
            ry = W'($urandom);
            if (ro == 4'hB && (i % 5) == 0) ry = '0;
            run_op(ro, rx, ry);
        end
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule